// File: doc/BRIEF.md
# Fractional-N Clock Oscillator Channel

This block derives an output clock from its own input clock with a long-term frequency ratio that need not be an integer. A divisor sets two candidate period lengths that differ by one clock. The top bit of a 32-bit phase accumulator picks one of them for each output period. After each period the accumulator adds one of two programmable increments, and the top bit also picks which one. With a positive step and a negative step, the accumulator swings around its midpoint. The long periods are then spread so that the average ratio matches the programmed fraction.

The input clock is the tick clock, running at twice the rate of the reference that the ratio is quoted against. Half-reference periods therefore come out exact. The coarse part of the divisor is held as the state of an 11-bit Galois LFSR, which the period logic counts down directly. Software configures the channel through five 32-bit registers. It clears the enable bit before reprogramming and sets it again to restart from a known accumulator value. Registers written while the channel runs are picked up at the next period boundary.

A state machine walks each period in two halves: first high, then low. Each half passes through the states WALK (LFSR stepping, two ticks per step), PAD (four fixed ticks) and TAIL (zero to two leftover ticks). That gives the states IDLE, HI_WALK, HI_PAD, HI_TAIL, LO_WALK, LO_PAD and LO_TAIL.

The transitions are:
- **start:** IDLE to HI_WALK or HI_PAD when enabled.
- **walk done:** WALK to PAD once the LFSR reaches all ones.
- **no walk:** straight to PAD when the loaded state is zero.
- **pad done:** PAD to TAIL, or on to the other half when there are no leftover ticks.
- **half done:** HI side to LO_WALK or LO_PAD.
- **wrap:** LO_PAD or LO_TAIL back to the HI side at the period end.
- **stop:** any state to IDLE when the enable bit is clear.

Top module: `nco_channel`

## Requirements
- R1: After reset the registers read CTRL 0, DIV 0, INC-up 0, INC-down 0 and SEED 0x8000_0000, and clk_out is low.
- R2: The registers sit at byte offsets CTRL 0, DIV 4, INC-up 8, INC-down 12 and SEED 16. CTRL keeps only bit 31. DIV keeps bits 12:0, with bits 12:2 as the LFSR state and bits 1:0 as the fine count. Other addresses read 0 and writes to them change nothing.
- R3: While CTRL bit 31 is clear, clk_out stays low. Clearing the bit while running brings clk_out low by the second rising edge after the edge that stores the write, and it stays low.
- R4: The coarse count c is 2 when the LFSR state is 0. Otherwise c is 3 plus the number of LFSR steps needed to go from the programmed state to 0x7FF. One step shifts the state right by one and XORs in 0x500 when the bit shifted out was 1.
- R5: Each output period lasts T = 4c + f + L clocks, where f is DIV[1:0] and L is the long flag.
- R6: Each period starts high and stays high for floor(T/2) clocks, then goes low for the remaining clocks.
- R7: L is 1 when the accumulator's bit 31 is 1 at the start of the period.
- R8: At the end of each period, the accumulator adds INC-down if its bit 31 is 1 and INC-up otherwise, modulo 2^32.
- R9: When the enable bit goes from 0 to 1, the accumulator is loaded from SEED and a new period starts. clk_out rises at the clock edge after the edge that stores the enable bit.
- R10: A write to DIV while running leaves the current period unchanged and takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (twice the reference rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| clk_out | output | 1 | Generated clock, registered |

## Verification
A register write is stored on the edge that samples it, and read data is combinational, so readback is sampled at the next falling edge. The enable bit takes one more edge to move the state machine: clk_out must still be low at the first falling edge after the write and high at the second. That slot is checked exactly, and a cleared enable is checked low two falling edges after the write. Period results are measured as run lengths of clk_out sampled at every falling edge, so they do not depend on absolute cycle numbers. A DIV write placed in the first high cycle of a period is expected to change only the period that follows.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // byte offsets of the channel registers
    localparam int OFS_CTRL    = 0;
    localparam int OFS_DIV     = 4;
    localparam int OFS_INC_UP  = 8;
    localparam int OFS_INC_DN  = 12;
    localparam int OFS_SEED    = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DIV,
        SEL_INC_UP,
        SEL_INC_DN,
        SEL_SEED
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_WALK,
        ST_HI_PAD,
        ST_HI_TAIL,
        ST_LO_WALK,
        ST_LO_PAD,
        ST_LO_TAIL
    } nco_state_e;

endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          DATA_W     = 32,
    parameter int          LFSR_W     = 11,
    parameter int          FINE_W     = 2,
    parameter int          EN_BIT     = 31,
    parameter logic [31:0] SEED_RESET = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                en,
    output logic [LFSR_W-1:0]   div_state,
    output logic [FINE_W-1:0]   div_fine,
    output logic [DATA_W-1:0]   inc_up,
    output logic [DATA_W-1:0]   inc_dn,
    output logic [DATA_W-1:0]   seed
);

    localparam int DIV_W = LFSR_W + FINE_W;

    reg_sel_e           sel;
    logic               en_q;
    logic [DIV_W-1:0]   div_q;
    logic [DATA_W-1:0]  up_q, dn_q, seed_q;

    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))
            sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_DIV))
            sel = SEL_DIV;
        else if (addr == ADDR_W'(OFS_INC_UP))
            sel = SEL_INC_UP;
        else if (addr == ADDR_W'(OFS_INC_DN))
            sel = SEL_INC_DN;
        else if (addr == ADDR_W'(OFS_SEED))
            sel = SEL_SEED;
        else
            sel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            div_q  <= '0;
            up_q   <= '0;
            dn_q   <= '0;
            seed_q <= DATA_W'(SEED_RESET);
        end else if (wr_en) begin
            unique case (sel)
                SEL_CTRL:   en_q   <= wdata[EN_BIT];
                SEL_DIV:    div_q  <= wdata[DIV_W-1:0];
                SEL_INC_UP: up_q   <= wdata;
                SEL_INC_DN: dn_q   <= wdata;
                SEL_SEED:   seed_q <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL:   rdata[EN_BIT]      = en_q;
            SEL_DIV:    rdata[DIV_W-1:0]   = div_q;
            SEL_INC_UP: rdata              = up_q;
            SEL_INC_DN: rdata              = dn_q;
            SEL_SEED:   rdata              = seed_q;
            default:    rdata              = '0;
        endcase
    end

    assign en        = en_q;
    assign div_state = div_q[DIV_W-1:FINE_W];
    assign div_fine  = div_q[FINE_W-1:0];
    assign inc_up    = up_q;
    assign inc_dn    = dn_q;
    assign seed      = seed_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              step,
    input  logic [ACC_W-1:0]  seed,
    input  logic [ACC_W-1:0]  inc_up,
    input  logic [ACC_W-1:0]  inc_dn,
    output logic [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]  up_act,
    output logic [ACC_W-1:0]  dn_act,
    output logic              sum_msb
);

    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] acc_q, up_q, dn_q, sum;

    // value the accumulator takes at the end of the running period
    assign sum     = acc_q + (acc_q[MSB] ? dn_q : up_q);
    assign sum_msb = sum[MSB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            up_q  <= '0;
            dn_q  <= '0;
        end else begin
            if (capture) begin
                up_q <= inc_up;
                dn_q <= inc_dn;
            end
            if (load)
                acc_q <= seed;
            else if (step)
                acc_q <= sum;
        end
    end

    assign acc    = acc_q;
    assign up_act = up_q;
    assign dn_act = dn_q;

endmodule

// File: rtl/nco_period_fsm.sv
module nco_period_fsm
    import nco_pkg::*;
#(
    parameter int LFSR_W      = 11,
    parameter int FINE_W      = 2,
    parameter int LFSR_POLY   = 'hA01,
    parameter int COARSE_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [LFSR_W-1:0]  div_state,
    input  logic [FINE_W-1:0]  div_fine,
    input  logic               long_fresh,
    input  logic               long_next,
    output logic               start_fresh,
    output logic               per_begin,
    output logic               per_end,
    output logic               clk_out
);

    localparam int               PAD_TICKS = 2 * COARSE_BASE;
    localparam int               EXT_W     = FINE_W + 1;
    localparam int               CNT_W     = $clog2(PAD_TICKS + (1 << FINE_W) + 1);
    localparam logic [LFSR_W-1:0] TAP      = LFSR_W'(LFSR_POLY >> 1);
    localparam logic [LFSR_W-1:0] TERM     = '1;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        lfsr_next = s[0] ? ((s >> 1) ^ TAP) : (s >> 1);
    endfunction

    function automatic nco_state_e half_entry(input logic hi, input logic [LFSR_W-1:0] s);
        if (s == '0)
            half_entry = hi ? ST_HI_PAD : ST_LO_PAD;
        else
            half_entry = hi ? ST_HI_WALK : ST_LO_WALK;
    endfunction

    nco_state_e         st_q, st_n;
    logic [LFSR_W-1:0]  lfsr_q, lfsr_n, hold_q, hold_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic               pair_q, pair_n;
    logic [EXT_W-1:0]   ehi_q, ehi_n, elo_q, elo_n;
    logic               fresh, wrap, go_lo;
    logic               out_q;

    // extra ticks of the coming period, split between the two halves
    logic               long_sel;
    logic [EXT_W-1:0]   ext_all, ext_hi, ext_lo;
    assign long_sel = (st_q == ST_IDLE) ? long_fresh : long_next;
    assign ext_all  = EXT_W'(div_fine) + EXT_W'(long_sel);
    assign ext_hi   = ext_all >> 1;
    assign ext_lo   = ext_all - ext_hi;

    always_comb begin
        st_n   = st_q;
        lfsr_n = lfsr_q;
        hold_n = hold_q;
        cnt_n  = cnt_q;
        pair_n = pair_q;
        ehi_n  = ehi_q;
        elo_n  = elo_q;
        fresh  = 1'b0;
        wrap   = 1'b0;
        go_lo  = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (en)
                    fresh = 1'b1;
            end
            ST_HI_WALK, ST_LO_WALK: begin
                if (pair_q) begin
                    if (lfsr_q == TERM) begin
                        st_n  = (st_q == ST_HI_WALK) ? ST_HI_PAD : ST_LO_PAD;
                        cnt_n = CNT_W'(PAD_TICKS - 1);
                    end else begin
                        lfsr_n = lfsr_next(lfsr_q);
                        pair_n = 1'b0;
                    end
                end else begin
                    pair_n = 1'b1;
                end
            end
            ST_HI_PAD: begin
                if (cnt_q == '0) begin
                    if (ehi_q == '0)
                        go_lo = 1'b1;
                    else begin
                        st_n  = ST_HI_TAIL;
                        cnt_n = CNT_W'(ehi_q) - 1'b1;
                    end
                end else
                    cnt_n = cnt_q - 1'b1;
            end
            ST_HI_TAIL: begin
                if (cnt_q == '0)
                    go_lo = 1'b1;
                else
                    cnt_n = cnt_q - 1'b1;
            end
            ST_LO_PAD: begin
                if (cnt_q == '0) begin
                    if (elo_q == '0)
                        wrap = 1'b1;
                    else begin
                        st_n  = ST_LO_TAIL;
                        cnt_n = CNT_W'(elo_q) - 1'b1;
                    end
                end else
                    cnt_n = cnt_q - 1'b1;
            end
            ST_LO_TAIL: begin
                if (cnt_q == '0)
                    wrap = 1'b1;
                else
                    cnt_n = cnt_q - 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase

        if (go_lo) begin
            st_n   = half_entry(1'b0, hold_q);
            lfsr_n = hold_q;
            pair_n = 1'b0;
            cnt_n  = CNT_W'(PAD_TICKS - 1);
        end

        if (fresh || wrap) begin
            st_n   = half_entry(1'b1, div_state);
            lfsr_n = div_state;
            hold_n = div_state;
            pair_n = 1'b0;
            cnt_n  = CNT_W'(PAD_TICKS - 1);
            ehi_n  = ext_hi;
            elo_n  = ext_lo;
        end

        if (!en) begin
            st_n  = ST_IDLE;
            fresh = 1'b0;
            wrap  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            lfsr_q <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
            pair_q <= 1'b0;
            ehi_q  <= '0;
            elo_q  <= '0;
        end else begin
            st_q   <= st_n;
            lfsr_q <= lfsr_n;
            hold_q <= hold_n;
            cnt_q  <= cnt_n;
            pair_q <= pair_n;
            ehi_q  <= ehi_n;
            elo_q  <= elo_n;
        end
    end

    // output register: high in every state of the first half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= (st_n == ST_HI_WALK) || (st_n == ST_HI_PAD) || (st_n == ST_HI_TAIL);
    end

    assign clk_out     = out_q;
    assign start_fresh = fresh;
    assign per_begin   = fresh | wrap;
    assign per_end     = wrap;

endmodule

// File: rtl/nco_channel.sv
module nco_channel #(
    parameter int          ADDR_W      = 5,
    parameter int          ACC_W       = 32,
    parameter int          LFSR_W      = 11,
    parameter int          FINE_W      = 2,
    parameter int          LFSR_POLY   = 'hA01,
    parameter int          COARSE_BASE = 2,
    parameter int          EN_BIT      = 31,
    parameter logic [31:0] SEED_RESET  = 32'h8000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [ACC_W-1:0]   reg_wdata,
    output logic [ACC_W-1:0]   reg_rdata,
    output logic               clk_out
);

    logic               ch_en;
    logic [LFSR_W-1:0]  div_state;
    logic [FINE_W-1:0]  div_fine;
    logic [ACC_W-1:0]   inc_up, inc_dn, seed;
    logic [ACC_W-1:0]   acc, up_act, dn_act;
    logic               sum_msb;
    logic               start_fresh, per_begin, per_end;

    nco_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (ACC_W),
        .LFSR_W     (LFSR_W),
        .FINE_W     (FINE_W),
        .EN_BIT     (EN_BIT),
        .SEED_RESET (SEED_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .en        (ch_en),
        .div_state (div_state),
        .div_fine  (div_fine),
        .inc_up    (inc_up),
        .inc_dn    (inc_dn),
        .seed      (seed)
    );

    nco_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_fresh),
        .capture (per_begin),
        .step    (per_end),
        .seed    (seed),
        .inc_up  (inc_up),
        .inc_dn  (inc_dn),
        .acc     (acc),
        .up_act  (up_act),
        .dn_act  (dn_act),
        .sum_msb (sum_msb)
    );

    nco_period_fsm #(
        .LFSR_W      (LFSR_W),
        .FINE_W      (FINE_W),
        .LFSR_POLY   (LFSR_POLY),
        .COARSE_BASE (COARSE_BASE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ch_en),
        .div_state   (div_state),
        .div_fine    (div_fine),
        .long_fresh  (seed[ACC_W-1]),
        .long_next   (sum_msb),
        .start_fresh (start_fresh),
        .per_begin   (per_begin),
        .per_end     (per_end),
        .clk_out     (clk_out)
    );

endmodule

// File: rtl/nco_channel_chk.sv
module nco_channel_chk #(
    parameter int ACC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              clk_out,
    input logic              start_fresh,
    input logic              per_end,
    input logic [ACC_W-1:0]  acc,
    input logic [ACC_W-1:0]  seed,
    input logic [ACC_W-1:0]  up_act,
    input logic [ACC_W-1:0]  dn_act
);

    localparam int MSB = ACC_W - 1;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_out);  // R3

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_fresh |=> acc == $past(seed));  // R9

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        per_end |=> acc == $past(acc) + ($past(acc[MSB]) ? $past(dn_act) : $past(up_act)));  // R8

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_end && !start_fresh) |=> $stable(acc));  // R8

    AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end || start_fresh) |=> clk_out);  // R6

    AST_NO_START_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(start_fresh || per_end));  // R3

endmodule

bind nco_channel nco_channel_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (ch_en),
    .clk_out     (clk_out),
    .start_fresh (start_fresh),
    .per_end     (per_end),
    .acc         (acc),
    .seed        (seed),
    .up_act      (up_act),
    .dn_act      (dn_act)
);

// File: tb/tb_nco_channel.sv
module tb_nco_channel;

    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [15:0] coarse;
        logic [1:0]  fine;
        logic [31:0] up;
        logic [31:0] dn;
        logic [31:0] seed;
        logic [7:0]  nper;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'd2,   2'd0, 32'h4000_0000, 32'hC000_0000, 32'h8000_0000, 8'd6},
        '{16'd3,   2'd3, 32'h2000_0000, 32'hA000_0000, 32'h0000_0000, 8'd6},
        '{16'd5,   2'd1, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 8'd4},
        '{16'd9,   2'd2, 32'h5555_5555, 32'hD555_5555, 32'h7FFF_FFFF, 8'd6},
        '{16'd2,   2'd3, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 8'd3},
        '{16'd300, 2'd1, 32'h3000_0000, 32'hB000_0000, 32'h1000_0000, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    nco_channel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_out   (clk_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [10:0] step11(input logic [10:0] s);
        step11 = s[0] ? ((s >> 1) ^ 11'h500) : (s >> 1);
    endfunction

    // LFSR state whose count to 0x7FF is c - 3 steps (0 for c == 2)
    function automatic logic [10:0] state_for(input int c);
        logic [10:0] s = 11'h7FF;
        if (c == 2) return 11'h000;
        for (int i = 0; i < 2048 - (c - 2); i++) s = step11(s);
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_rise();
        bit prev = clk_out;
        bit seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            if (clk_out && !prev) seen = 1'b1;
            prev = clk_out;
        end
    endtask

    // called at the negedge of a period's first high cycle; returns at the next one
    task automatic meas(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (clk_out) begin hi++; @(negedge clk); end
        while (!clk_out) begin lo++; @(negedge clk); end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        int hi, lo, t, hi_rest;
        bit stayed_low;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(5'd0, d);  check("R1 ctrl reset", d, 32'h0);
        rd(5'd4, d);  check("R1 div reset", d, 32'h0);
        rd(5'd8, d);  check("R1 inc-up reset", d, 32'h0);
        rd(5'd12, d); check("R1 inc-down reset", d, 32'h0);
        rd(5'd16, d); check("R1 seed reset", d, 32'h8000_0000);
        check("R1 clk_out low", 32'(clk_out), 32'h0);

        // R2 field widths and unmapped space
        wr(5'd0, 32'h7FFF_FFFF);
        rd(5'd0, d);  check("R2 ctrl keeps bit 31 only", d, 32'h0);
        wr(5'd4, 32'hFFFF_FFFF);
        rd(5'd4, d);  check("R2 div keeps bits 12:0", d, 32'h0000_1FFF);
        wr(5'd8, 32'h1234_5678);
        rd(5'd8, d);  check("R2 inc-up readback", d, 32'h1234_5678);
        wr(5'd20, 32'hFFFF_FFFF);
        rd(5'd20, d); check("R2 unmapped reads zero", d, 32'h0);
        rd(5'd4, d);  check("R2 unmapped write ignored", d, 32'h0000_1FFF);
        rd(5'd0, d);  check("R2 unmapped write leaves ctrl", d, 32'h0);

        // R3 disabled channel stays quiet
        stayed_low = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (clk_out) stayed_low = 1'b0;
            @(negedge clk);
        end
        check("R3 low while disabled", 32'(stayed_low), 32'h1);

        // vector table: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] acc_m;
            int c, f, lng;
            c = int'(VECS[v].coarse);
            f = int'(VECS[v].fine);
            wr(5'd0, 32'h0);
            wr(5'd4, {19'd0, state_for(c), VECS[v].fine});
            wr(5'd8, VECS[v].up);
            wr(5'd12, VECS[v].dn);
            wr(5'd16, VECS[v].seed);
            wr(5'd0, 32'h8000_0000);
            wait_rise();
            acc_m = VECS[v].seed;  // R9 reload
            for (int p = 0; p < int'(VECS[v].nper); p++) begin
                lng = int'(acc_m[31]);  // R7
                t   = 4 * c + f + lng;  // R4 R5
                meas(hi, lo);
                check($sformatf("R4 R5 R7 R8 R9 vec %0d period %0d length", v, p),
                      32'(hi + lo), 32'(t));
                check($sformatf("R6 vec %0d period %0d high time", v, p),
                      32'(hi), 32'(t / 2));
                acc_m = acc_m + (acc_m[31] ? VECS[v].dn : VECS[v].up);  // R8
            end
        end

        // R9 start timing, then R10 live DIV write
        wr(5'd0, 32'h0);
        wr(5'd4, {19'd0, state_for(3), 2'd0});
        wr(5'd8, 32'h0);
        wr(5'd12, 32'h0);
        wr(5'd16, 32'h0);
        @(negedge clk);
        wr(5'd0, 32'h8000_0000);
        check("R9 still low one edge after enable stored", 32'(clk_out), 32'h0);
        @(negedge clk);
        check("R9 high on following edge", 32'(clk_out), 32'h1);
        wr(5'd4, {19'd0, state_for(3), 2'd3});  // first high cycle consumed
        meas(hi_rest, lo);
        check("R10 current period high unchanged", 32'(hi_rest + 1), 32'd6);
        check("R10 current period low unchanged", 32'(lo), 32'd6);
        meas(hi, lo);
        check("R10 next period high", 32'(hi), 32'd7);
        check("R10 next period low", 32'(lo), 32'd8);

        // R3 disable while running
        wr(5'd0, 32'h0);
        @(negedge clk);
        check("R3 low after disable", 32'(clk_out), 32'h0);
        stayed_low = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (clk_out) stayed_low = 1'b0;
            @(negedge clk);
        end
        check("R3 stays low after disable", 32'(stayed_low), 32'h1);

        summary();
    end

endmodule